// File: doc/BRIEF.md
# Rectangle Fill Engine with Raster Operation

This block fills an axis-aligned rectangle in a frame store that holds 32 bits per pixel. It uses a constant colour and a selectable raster operation. Software programs the engine through a small register write port. It first sets a draw-operation code and optionally the colour, raster code and plane mask. It then writes the top row, left column, height and width. The width write launches the fill.

The engine walks the rectangle row by row, with the column advancing fastest. For each pixel it issues a request on a simple synchronous memory port. When the result does not depend on the old pixel and every plane is enabled, the request is a single write. Otherwise the engine reads the pixel, waits a fixed read latency, and writes back the combined value through the plane mask. While the walk runs, `busy` is high and `reg_ready` is low. Register writes that arrive during a fill are held off until it ends.

Top module: `rect_fill`

## Requirements
- R1: After reset `busy` is low, `reg_ready` is high and `mem_req` is low. The colour resets to 0, the raster code to 0x83 (copy) and the plane mask to all ones. A fill issued with only geometry written therefore writes 0 to each pixel and issues no reads.
- R2: `reg_sel` decodes as follows: 0 = draw-op code, 1 = top row Y, 2 = left column X, 3 = height, 4 = width, 5 = colour, 6 = raster code, 7 = plane mask. A width write starts a fill only when the stored draw-op code is 0x08. With any other code, for example 0x09, the write only stores the width and no memory access follows.
- R3: The pixel at (x, y) sits at byte address y*8192 + x*4. Pixels are visited row by row, with x increasing fastest.
- R4: Raster code 0x83 with an all-ones plane mask writes the colour register to every pixel, without reading memory. The colour holds blue in 23:16, green in 15:8 and red in 7:0, and passes through unchanged.
- R5: Raster code 0x86 reads each pixel and writes back the colour XOR the old value.
- R6: Raster code 0x85 reads each pixel and writes back the old value, so memory is left unchanged.
- R7: Plane-mask bits that are 0 keep the old pixel bits. A mask other than all ones forces a read before each write, whatever the raster code.
- R8: A fill whose height or width is zero raises no `busy` and makes no memory access.
- R9: `busy` stays high until the last pixel write has been accepted (`mem_req` and `mem_ready` both high). A request holds its address and type while `mem_ready` is low.
- R10: While `busy` is high, `reg_ready` is low. A register write held across the fill takes effect after it ends and is not lost.
- R11: Read data is taken from `mem_rdata` exactly RD_LAT cycles after the cycle in which the read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Register write accepted when high |
| busy | output | 1 | Fill in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | Y_W+13 | Byte address of the pixel |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid RD_LAT cycles after an accepted read |

## Verification
The bench targets several corner cases.

- **Read timing.** Read data from the memory model is valid only in the one cycle the latency allows; every other cycle returns a poison word. A design that samples early or late writes garbage into the XOR and keep-old fills.
- **Stalls.** Back-pressure on `mem_ready` exposes a walk that advances or drops `busy` before a write is accepted. Such a design shows missing pixels or a short write count.
- **Zero size and other op codes.** Zero-sized rectangles and a draw-op code other than 0x08 catch a design that launches anyway; it shows up as stray memory traffic.
- **Held writes and plane mask.** A colour write held during a fill catches a design that drops or applies it early. The partial plane mask catches a design that writes without reading first.

// File: rtl/rect_fill.sv
module rect_fill #(
  parameter int X_W = 11,
  parameter int Y_W = 11,
  parameter int LINE_SHIFT = 13,
  parameter int RD_LAT = 2,
  localparam int ADDR_W = Y_W + LINE_SHIFT,
  localparam int LAT_W = $clog2(RD_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              reg_ready,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  localparam logic [7:0] OP_RECT = 8'h08;
  localparam logic [7:0] ROP_NEW = 8'h83;
  localparam logic [7:0] ROP_OLD = 8'h85;
  localparam logic [7:0] ROP_XOR = 8'h86;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} st_t;
  st_t st;

  logic [7:0]     drawop, rop;
  logic [31:0]    fg, pmask, old_pix, res;
  logic [Y_W-1:0] top, hgt, cy, row;
  logic [X_W-1:0] left, wid, cx, col;
  logic [LAT_W-1:0] lat;

  wire take     = reg_we && reg_ready;
  wire start    = take && reg_sel == 3'd4 && drawop == OP_RECT &&
                  reg_wdata[X_W-1:0] != '0 && hgt != '0;
  wire need_rd  = rop == ROP_OLD || rop == ROP_XOR || pmask != '1;
  wire acc      = mem_req && mem_ready;
  wire last_col = col == wid - 1'b1;
  wire last_row = row == hgt - 1'b1;
  wire st_t nxt = need_rd ? S_RD : S_WR;

  assign busy      = st != S_IDLE;
  assign reg_ready = !busy;
  assign mem_req   = st == S_RD || st == S_WR;
  assign mem_we    = st == S_WR;
  assign mem_addr  = (ADDR_W'(cy) << LINE_SHIFT) + (ADDR_W'(cx) << 2);

  always_comb begin
    case (rop)
      ROP_OLD: res = old_pix;
      ROP_XOR: res = fg ^ old_pix;
      default: res = fg;
    endcase
  end
  assign mem_wdata = (res & pmask) | (old_pix & ~pmask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drawop  <= '0;
      rop     <= ROP_NEW;
      fg      <= '0;
      pmask   <= '1;
      top     <= '0;
      left    <= '0;
      hgt     <= '0;
      wid     <= '0;
      st      <= S_IDLE;
      cx      <= '0;
      cy      <= '0;
      col     <= '0;
      row     <= '0;
      lat     <= '0;
      old_pix <= '0;
    end else begin
      if (take) begin
        case (reg_sel)
          3'd0: drawop <= reg_wdata[7:0];
          3'd1: top    <= reg_wdata[Y_W-1:0];
          3'd2: left   <= reg_wdata[X_W-1:0];
          3'd3: hgt    <= reg_wdata[Y_W-1:0];
          3'd4: wid    <= reg_wdata[X_W-1:0];
          3'd5: fg     <= reg_wdata;
          3'd6: rop    <= reg_wdata[7:0];
          default: pmask <= reg_wdata;
        endcase
      end
      case (st)
        S_IDLE: if (start) begin
          cx  <= left;
          cy  <= top;
          col <= '0;
          row <= '0;
          st  <= nxt;
        end
        S_RD: if (acc) begin
          lat <= LAT_W'(1);
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (lat == LAT_W'(RD_LAT)) begin
            old_pix <= mem_rdata;
            st      <= S_WR;
          end else begin
            lat <= lat + 1'b1;
          end
        end
        S_WR: if (acc) begin
          if (last_col) begin
            col <= '0;
            cx  <= left;
            if (last_row) begin
              st <= S_IDLE;
            end else begin
              row <= row + 1'b1;
              cy  <= cy + 1'b1;
              st  <= nxt;
            end
          end else begin
            col <= col + 1'b1;
            cx  <= cx + 1'b1;
            st  <= nxt;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rect_fill_chk.sv
module rect_fill_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !mem_we |=> !mem_req); // R11

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_req && mem_we && mem_ready)); // R9

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R3
endmodule

bind rect_fill rect_fill_chk #(.AW(ADDR_W)) u_chk (.*);

// File: tb/sim_rect_fill.sv
`timescale 1ns/1ps
module sim_rect_fill;
  localparam int RDL = 2;
  localparam int AW  = 24;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n, reg_we, reg_ready, busy, mem_req, mem_we, mem_ready;
  logic [2:0] reg_sel;
  logic [31:0] reg_wdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  rect_fill #(.RD_LAT(RDL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  int checks = 0, errors = 0, cyc = 0;
  logic stall = 0;
  logic [31:0] mem_m [256];
  logic [31:0] exp_m [256];
  logic [31:0] rpipe [RDL];
  logic vpipe [RDL];
  int nwr, nrd;
  logic [AW-1:0] last_a, prev_a;

  function automatic logic [7:0] idx(input logic [AW-1:0] a);
    return {a[16:13], a[5:2]};
  endfunction
  function automatic logic [31:0] initv(input int i);
    return 32'h9E3779B9 * (i + 1);
  endfunction

  assign mem_rdata = vpipe[RDL-1] ? rpipe[RDL-1] : 32'hBAD0BAD0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= initv(i);
      for (int i = 0; i < RDL; i++) begin rpipe[i] <= '0; vpipe[i] <= 1'b0; end
      nwr <= 0; nrd <= 0; last_a <= '0; prev_a <= '0;
    end else begin
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          mem_m[idx(mem_addr)] <= mem_wdata;
          nwr <= nwr + 1;
          prev_a <= last_a;
          last_a <= mem_addr;
        end else nrd <= nrd + 1;
      end
      rpipe[0] <= mem_m[idx(mem_addr)];
      vpipe[0] <= mem_req && mem_ready && !mem_we;
      for (int i = 1; i < RDL; i++) begin rpipe[i] <= rpipe[i-1]; vpipe[i] <= vpipe[i-1]; end
    end
  end

  always @(negedge clk) mem_ready <= !stall || (cyc % 3 == 1);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d, output int waited);
    bit r;
    waited = 0;
    reg_we = 1; reg_sel = s; reg_wdata = d;
    r = reg_ready;
    while (!r) begin @(negedge clk); waited++; r = reg_ready; end
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    int w;
    wreg(s, d, w);
  endtask

  task automatic run(input int y, input int x, input int h, input int w);
    int n = 0;
    wr(3'd1, y); wr(3'd2, x); wr(3'd3, h); wr(3'd4, w);
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic model(input int y, input int x, input int h, input int w,
                       input logic [7:0] rop, input logic [31:0] fg, input logic [31:0] pm);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        int i = (y + r) * 16 + (x + c);
        logic [31:0] o = exp_m[i], v;
        v = (rop == 8'h85) ? o : (rop == 8'h86) ? (fg ^ o) : fg;
        exp_m[i] = (v & pm) | (o & ~pm);
      end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, fi = 0;
    for (int i = 0; i < 256; i++) if (mem_m[i] !== exp_m[i]) begin
      if (bad == 0) fi = i;
      bad++;
    end
    check(bad == 0, req, mem_m[fi], exp_m[fi]);
  endtask

  task automatic t_reset;
    check(busy === 1'b0 && reg_ready === 1'b1 && mem_req === 1'b0, "R1 reset outputs",
          {29'b0, busy, reg_ready, mem_req}, 32'h2);
  endtask

  task automatic t_defaults;
    int w0 = nwr, r0 = nrd;
    wr(3'd0, 32'h08);
    run(0, 0, 1, 2);
    model(0, 0, 1, 2, 8'h83, 32'h0, 32'hFFFFFFFF);
    check(nwr - w0 == 2 && nrd == r0, "R1 default fill counts", nwr - w0, 2);
    cmp_mem("R1 default fill memory");
  endtask

  task automatic t_copy;
    int w0 = nwr, r0 = nrd;
    wr(3'd5, 32'h00123456);
    run(1, 2, 3, 4);
    model(1, 2, 3, 4, 8'h83, 32'h00123456, 32'hFFFFFFFF);
    check(nwr - w0 == 12 && nrd == r0, "R4 copy write-only", nrd - r0, 0);
    cmp_mem("R4 copy memory");
    check(last_a == 24'(3 * 8192 + 5 * 4), "R3 last address", 32'(last_a), 3 * 8192 + 20);
    check(prev_a == 24'(3 * 8192 + 4 * 4), "R3 x fastest order", 32'(prev_a), 3 * 8192 + 16);
  endtask

  task automatic t_zero;
    int a0 = nwr + nrd;
    run(4, 4, 0, 5);
    check(busy === 1'b0, "R8 zero height busy", busy, 0);
    run(4, 4, 2, 0);
    repeat (4) @(negedge clk);
    check(nwr + nrd == a0 && busy === 1'b0, "R8 zero size no access", nwr + nrd - a0, 0);
    cmp_mem("R8 memory untouched");
  endtask

  task automatic t_other_op;
    int a0 = nwr + nrd;
    wr(3'd0, 32'h09);
    run(5, 5, 2, 2);
    repeat (4) @(negedge clk);
    check(nwr + nrd == a0 && busy === 1'b0, "R2 op 0x09 ignored", nwr + nrd - a0, 0);
    wr(3'd0, 32'h0B);
    run(5, 5, 2, 2);
    check(nwr + nrd == a0, "R2 op 0x0B ignored", nwr + nrd - a0, 0);
    wr(3'd0, 32'h08);
  endtask

  task automatic t_xor_stall;
    int w0 = nwr, r0 = nrd;
    stall = 1;
    wr(3'd6, 32'h86); wr(3'd5, 32'h0F0F0F0F);
    run(6, 1, 2, 5);
    model(6, 1, 2, 5, 8'h86, 32'h0F0F0F0F, 32'hFFFFFFFF);
    check(nwr - w0 == 10 && nrd - r0 == 10, "R9 R5 stalled xor counts", nwr - w0, 10);
    cmp_mem("R5 R11 xor memory");
    stall = 0;
  endtask

  task automatic t_keep;
    int r0 = nrd;
    wr(3'd6, 32'h85); wr(3'd5, 32'hFFFFFFFF);
    run(1, 2, 3, 4);
    model(1, 2, 3, 4, 8'h85, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check(nrd - r0 == 12, "R6 keep reads", nrd - r0, 12);
    cmp_mem("R6 keep memory");
  endtask

  task automatic t_mask;
    int r0 = nrd;
    wr(3'd6, 32'h83); wr(3'd5, 32'hAABBCCDD); wr(3'd7, 32'h00FF00FF);
    run(9, 3, 2, 3);
    model(9, 3, 2, 3, 8'h83, 32'hAABBCCDD, 32'h00FF00FF);
    check(nrd - r0 == 6, "R7 mask forces read", nrd - r0, 6);
    cmp_mem("R7 masked memory");
    wr(3'd7, 32'hFFFFFFFF);
  endtask

  task automatic t_hold;
    int waited, n = 0;
    wr(3'd5, 32'h11111111);
    wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 2); wr(3'd4, 8);
    check(reg_ready === 1'b0 && busy === 1'b1, "R10 not ready while busy", reg_ready, 0);
    wreg(3'd5, 32'h22222222, waited);
    check(waited > 0, "R10 write held off", waited, 1);
    model(0, 0, 2, 8, 8'h83, 32'h11111111, 32'hFFFFFFFF);
    cmp_mem("R10 fill used old colour");
    run(12, 12, 1, 1);
    model(12, 12, 1, 1, 8'h83, 32'h22222222, 32'hFFFFFFFF);
    cmp_mem("R10 held colour applied");
  endtask

  initial begin
    bit dead = 0;
    fork
      begin
        reg_we = 0; reg_sel = '0; reg_wdata = '0; rst_n = 0;
        for (int i = 0; i < 256; i++) exp_m[i] = initv(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_copy();
        t_zero();
        t_other_op();
        t_xor_stall();
        t_keep();
        t_mask();
        t_hold();
      end
      begin
        repeat (100000) @(posedge clk);
        dead = 1;
      end
    join_any
    disable fork;
    if (dead) check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule